// File: doc/BRIEF.md
# Shift-Register Driven Eight-State Sequence Generator

This block produces a fixed cycle of eight 4-bit codes by steering a universal shift register instead of using a free next-state table or a counter. The register can hold, shift toward the least significant end, shift toward the most significant end, or load a parallel word. Small combinational logic looks at the current code and picks one of these actions together with the serial bit that enters. The cycle runs 0000, 1000, 0001, 0011, 0110, 1101, 1110, 1111 and back to 0000. The leftmost bit is the most significant.

The action is picked from the number of ones in the current code. Zero or three ones shift right, with a 1 entering at the top. One or two ones shift left, and the bit entering at the bottom is the NAND of the two lowest bits. Four ones load the all-zero parallel word. Codes outside the cycle obey the same rule and fall into the cycle within a few clocks. An enable gates every step. A wrap output flags the clock on which the cycle closes.

Top module: `seqgen_usr`

## Requirements
- R1: With enable high, the state steps on each rising clock edge through 0000 → 1000 → 0001 → 0011 → 0110 → 1101 → 1110 → 1111 → 0000, repeating without end.
- R2: The internal 2-bit mode select uses 00 = hold, 10 = shift right, 01 = shift left, 11 = load. The logic picks shift right for codes with zero or three ones, shift left for one or two ones, and load for four ones.
- R3: A right shift moves each bit one place toward bit 0 and puts 1 into bit 3. A left shift moves each bit one place toward bit 3 and puts NAND(bit 1, bit 0) into bit 0, so only 0011 takes a 0 there.
- R4: Load takes an all-zero parallel word, so 1111 is followed by 0000.
- R5: When `rst_n` is low at a rising clock edge, the state becomes the parameter `CLEAR_STATE` (default 0000), whatever `en` is.
- R6: When `en` is low at a rising clock edge (and `rst_n` is high), the mode is forced to hold and the state does not change.
- R7: `wrap` is high exactly while `en` is high and the state is 1111. It is combinational, so it lasts one clock when stepping.
- R8: The codes 0010, 0100, 0101, 0111, 1001, 1010, 1011 and 1100 follow the R2/R3 rule and reach a code in the R1 cycle within at most 3 enabled clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low clear, sampled on the clock edge |
| en | input | 1 | Step enable; low holds the state |
| state | output | 4 | Current register code, bit 3 leftmost |
| wrap | output | 1 | High during the clock that closes the cycle |

## Verification
The assertions assume that `rst_n` is driven low from time zero until at least one rising edge has passed. They also assume that `en` and `rst_n` change only away from the rising edge. The off-cycle bound counts only enabled clocks, so it relies on the stimulus not holding the register in an off-cycle code forever. The bench changes inputs only on falling edges. It reaches the off-cycle codes through the `CLEAR_STATE` parameter of extra instances, one per code, and never forces internal state.

// File: rtl/seqgen_usr_pkg.sv
// Package: shared width, mode encoding and load word for the sequence generator.
// Assumes a 4-bit state; the mode codes are fixed by the step rule.
package seqgen_usr_pkg;

    localparam int unsigned SEQ_W = 4;
    localparam int unsigned CNT_W = $clog2(SEQ_W + 1);

    typedef enum logic [1:0] {
        MODE_HOLD  = 2'b00,
        MODE_SHR   = 2'b10,
        MODE_SHL   = 2'b01,
        MODE_LOAD  = 2'b11
    } usr_mode_e;

    localparam logic [SEQ_W-1:0] LOAD_WORD = '0;

endpackage

// File: rtl/bit_ones.sv
// Module: bit_ones
// Counts the set bits of a word with a generate-built adder chain.
// Assumes CNT_W bits are enough for W (CNT_W >= clog2(W+1)).
module bit_ones #(
    parameter int unsigned W     = 4,
    parameter int unsigned CNT_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     word,
    output logic [CNT_W-1:0] ones
);

    logic [CNT_W-1:0] partial [W+1];

    assign partial[0] = '0;

    for (genvar b = 0; b < W; b++) begin : g_add
        // Running sum stage: add one bit to the previous total.
        assign partial[b+1] = partial[b] + CNT_W'(word[b]);
    end

    assign ones = partial[W];

endmodule

// File: rtl/usr_reg.sv
// Module: usr_reg
// Universal shift register: hold, shift right (serial bit into MSB),
// shift left (serial bit into LSB) or parallel load, by mode select.
// Assumes a synchronous active-low clear to CLEAR_VAL.
module usr_reg
    import seqgen_usr_pkg::*;
#(
    parameter int unsigned     W         = SEQ_W,
    parameter logic [W-1:0]    CLEAR_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  usr_mode_e     mode,
    input  logic          msb_in,
    input  logic          lsb_in,
    input  logic [W-1:0]  par_in,
    output logic [W-1:0]  q
);

    logic [W-1:0] q_r;

    // Register update: clear, then act on the selected mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r <= CLEAR_VAL;
        end else begin
            case (mode)
                MODE_SHR:  q_r <= {msb_in, q_r[W-1:1]};
                MODE_SHL:  q_r <= {q_r[W-2:0], lsb_in};
                MODE_LOAD: q_r <= par_in;
                default:   q_r <= q_r;
            endcase
        end
    end

    assign q = q_r;

endmodule

// File: rtl/seq_step_ctrl.sv
// Module: seq_step_ctrl
// Picks the shift mode and the two serial bits from the current code.
// Assumes a 4-bit code; the ones-count rule is defined for that width.
module seq_step_ctrl
    import seqgen_usr_pkg::*;
(
    input  logic             en,
    input  logic [SEQ_W-1:0] state,
    output usr_mode_e        mode,
    output logic             msb_in,
    output logic             lsb_in,
    output logic             wrap
);

    logic [CNT_W-1:0] ones;
    usr_mode_e        rule_mode;

    bit_ones #(.W(SEQ_W), .CNT_W(CNT_W)) u_ones (
        .word (state),
        .ones (ones)
    );

    // Mode rule: zero or three ones shift right, one or two shift left, all ones load.
    always_comb begin
        if (ones == CNT_W'(SEQ_W)) begin
            rule_mode = MODE_LOAD;
        end else if (ones == CNT_W'(0) || ones == CNT_W'(3)) begin
            rule_mode = MODE_SHR;
        end else begin
            rule_mode = MODE_SHL;
        end
    end

    // Enable gate: a low enable turns every step into a hold.
    always_comb begin
        mode = en ? rule_mode : MODE_HOLD;
    end

    assign msb_in = 1'b1;
    assign lsb_in = ~(state[1] & state[0]);
    assign wrap   = (mode == MODE_LOAD);

endmodule

// File: rtl/seqgen_usr.sv
// Module: seqgen_usr (top)
// Eight-state sequence generator: a universal shift register stepped by
// a mode picked from the current code. Assumes inputs change away from
// the rising clock edge.
module seqgen_usr
    import seqgen_usr_pkg::*;
#(
    parameter logic [SEQ_W-1:0] CLEAR_STATE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [SEQ_W-1:0] state,
    output logic             wrap
);

    usr_mode_e mode;
    logic      msb_in;
    logic      lsb_in;

    seq_step_ctrl u_ctrl (
        .en     (en),
        .state  (state),
        .mode   (mode),
        .msb_in (msb_in),
        .lsb_in (lsb_in),
        .wrap   (wrap)
    );

    usr_reg #(.W(SEQ_W), .CLEAR_VAL(CLEAR_STATE)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .msb_in (msb_in),
        .lsb_in (lsb_in),
        .par_in (LOAD_WORD),
        .q      (state)
    );

endmodule

// File: rtl/seqgen_usr_chk.sv
// Module: seqgen_usr_chk
// Property checker bound to seqgen_usr. Assumes rst_n is low from time zero.
module seqgen_usr_chk
    import seqgen_usr_pkg::*;
#(
    parameter logic [SEQ_W-1:0] CLEAR_STATE = '0,
    parameter int unsigned      MAX_OFF     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEQ_W-1:0] state,
    input  logic             wrap
);

    function automatic logic on_cycle(input logic [SEQ_W-1:0] s);
        return s inside {4'h0, 4'h8, 4'h1, 4'h3, 4'h6, 4'hD, 4'hE, 4'hF};
    endfunction

    logic [3:0] off_cnt;

    // Count enabled clocks spent outside the main cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_cnt <= '0;
        end else if (en) begin
            if (on_cycle(state)) off_cnt <= '0;
            else if (off_cnt != 4'hF) off_cnt <= off_cnt + 4'd1;
        end
    end

    AST_CLEAR_LOADS: assert property (@(posedge clk) !rst_n |=> state == CLEAR_STATE); // R5
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !en |=> $stable(state)); // R6
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n) wrap |=> state == 4'h0); // R4
    AST_WRAP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) wrap |-> en); // R7
    AST_STEP_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state != 4'hF) |=> (($countones(state) <= $countones($past(state)) + 1) &&
                                   ($countones($past(state)) <= $countones(state) + 1))); // R3
    AST_RIGHT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ($countones(state) == 0 || $countones(state) == 3)) |=> state[3]); // R2
    AST_NAND_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (en && state == 4'h3) |=> state == 4'h6); // R1
    AST_OFF_BOUND: assert property (@(posedge clk) disable iff (!rst_n) off_cnt <= 4'(MAX_OFF)); // R8

endmodule

bind seqgen_usr seqgen_usr_chk #(.CLEAR_STATE(CLEAR_STATE)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .state (state),
    .wrap  (wrap)
);

// File: tb/test_seqgen_usr.sv
// Bench for seqgen_usr: behavioural reference model compared every clock.
module test_seqgen_usr;

    localparam int CLK_PERIOD = 10;
    localparam int OFF_N      = 8;
    localparam logic [3:0] OFF_INIT [OFF_N] = '{4'h2, 4'h4, 4'h5, 4'h7, 4'h9, 4'hA, 4'hB, 4'hC};

    logic clk = 1'b0;
    logic rst_n;
    logic en;
    logic [3:0] state;
    logic wrap;
    logic [3:0] off_state [OFF_N];
    logic       off_wrap  [OFF_N];

    int total = 0;
    int bad   = 0;
    int m_state;
    int off_model [OFF_N];
    int cyc_q [$] = '{0, 8, 1, 3, 6, 13, 14, 15};

    always #(CLK_PERIOD / 2) clk = ~clk;

    seqgen_usr i_seqgen_usr (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .state (state),
        .wrap  (wrap)
    );

    for (genvar k = 0; k < OFF_N; k++) begin : g_off
        seqgen_usr #(.CLEAR_STATE(OFF_INIT[k])) i_off (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en),
            .state (off_state[k]),
            .wrap  (off_wrap[k])
        );
    end

    // Reference next code from the stated rule (ones count picks the action).
    function automatic int ref_next(input int s);
        int ones = 0;
        for (int b = 0; b < 4; b++) ones += (s >> b) & 1;
        if (ones == 4) return 0;
        if (ones == 0 || ones == 3) return 8 | (s >> 1);
        return ((s << 1) & 14) | (((s & 3) == 3) ? 0 : 1);
    endfunction

    function automatic bit in_cycle(input int s);
        foreach (cyc_q[i]) if (cyc_q[i] == s) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock: drive at falling edge, check wrap, then state after the edge.
    task automatic step(input logic r, input logic e, input string req);
        rst_n = r;
        en    = e;
        #1;
        check("R7 wrap", int'(wrap), (e && m_state == 15) ? 1 : 0);
        @(posedge clk);
        m_state = !r ? 0 : (!e ? m_state : ref_next(m_state));
        for (int k = 0; k < OFF_N; k++)
            off_model[k] = !r ? int'(OFF_INIT[k]) : (!e ? off_model[k] : ref_next(off_model[k]));
        @(negedge clk);
        check(req, int'(state), m_state);
        for (int k = 0; k < OFF_N; k++)
            check("R8 off-cycle path", int'(off_state[k]), off_model[k]);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        rst_n   = 1'b0;
        en      = 1'b0;
        m_state = 0;
        for (int k = 0; k < OFF_N; k++) off_model[k] = int'(OFF_INIT[k]);
        @(negedge clk);
        step(1'b0, 1'b1, "R5 clear with enable high");
        step(1'b0, 1'b0, "R5 clear with enable low");

        // Three full periods against the listed cycle.
        for (int i = 0; i < 24; i++) begin
            int prev = m_state;
            step(1'b1, 1'b1, (prev == 15) ? "R4 load zero" : "R2 R3 shift step");
            check("R1 cycle order", int'(state), cyc_q[(i + 1) % 8]);
            if (i == 2)
                for (int k = 0; k < OFF_N; k++)
                    check("R8 reached cycle", int'(in_cycle(int'(off_state[k]))), 1);
        end

        // Advance to 0110, then hold.
        repeat (4) step(1'b1, 1'b1, "R1 advance");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, "R6 hold");
        check("R6 held value", int'(state), 6);

        // Hold at 1111: wrap must stay low while enable is low.
        repeat (3) step(1'b1, 1'b1, "R1 advance");
        step(1'b1, 1'b0, "R6 hold at top");
        check("R7 wrap low when idle", int'(wrap), 0);
        step(1'b1, 1'b1, "R4 load zero");

        // Mid-cycle clear with enable low.
        repeat (3) step(1'b1, 1'b1, "R1 advance");
        step(1'b0, 1'b0, "R5 clear mid-cycle");
        check("R5 cleared", int'(state), 0);

        // Toggled enable pattern.
        for (int i = 0; i < 20; i++) step(1'b1, (i % 3) != 1, "R6 R1 mixed enable");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule